// File: doc/BRIEF.md
# Effective Address Generator Unit

This block turns one operand request into a byte address in a 64 KB data space that is laid out as 16-bit words. A small file of sixteen 16-bit pointer registers sits inside it. Each request names an addressing mode, an access size (byte or word), a step direction, a pointer register, a second register for register-offset mode, and a 16-bit literal. The block answers one clock later with the effective address. It also updates the pointer when the mode modifies it.

The block knows seven modes. An absolute address can come from the literal. A register can be read or written directly. A pointer can be used as is, stepped after use, or stepped before use. A pointer can also have a second register or the literal added to it. A word access at an odd address does not produce an address. Instead it raises a one-cycle error strobe, and the pointer keeps its old value. The address arithmetic wraps modulo 2^16. A modify step is 1 for bytes and 2 for words.

A request is accepted on every clock edge where `req_vld` is high, so requests can run back to back. A pointer updated by one request is seen by the request in the next cycle.

Top module: `eagu_top`

## Requirements
- R1: After synchronous reset, `ea_vld`, `err_strb` and `rd_vld` are low, and all sixteen registers read back as 0x0000.
- R2: Mode code 0 (absolute) gives `ea_addr` equal to `req_lit`. No register is changed.
- R3: Mode code 1 (register direct) raises `rd_vld` with `rd_data` set to the register's value before the request. When `req_wr` is also high, the register takes `req_wdata`. Mode 1 never raises `ea_vld` or `err_strb`.
- R4: Mode code 2 (indirect) gives `ea_addr` equal to the pointer register. The pointer does not change.
- R5: Mode code 3 (post-step) gives `ea_addr` equal to the old pointer. The pointer is then moved by the step: +1 for a byte or +2 for a word, or minus that step when `req_dec` is 1. The new value wraps modulo 2^16.
- R6: Mode code 4 (pre-step) moves the pointer by the step first, with the same step and wrap rules as R5. The moved value is both `ea_addr` and the value written back.
- R7: Mode code 5 (register offset) gives `ea_addr` = pointer + register `req_ofs`, modulo 2^16. No register is changed.
- R8: Mode code 6 (literal offset) gives `ea_addr` = pointer + `req_lit`, modulo 2^16. No register is changed.
- R9: In a memory mode (codes 0, 2 to 6), a word access (`req_word`=1) whose address bit 0 is 1 raises `err_strb` for one cycle and does not raise `ea_vld`. A byte access never raises `err_strb`.
- R10: When `err_strb` is raised, the pointer write-back is suppressed and the register keeps its old value.
- R11: Mode code 7 is reserved. It raises no output strobe and changes no register.
- R12: All outputs are registered and appear in the cycle after the request. At most one of `ea_vld`, `err_strb`, `rd_vld` is high, and all three are low after a cycle without `req_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code, 0 to 7 |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_dec | input | 1 | 1 = step downward in modes 3 and 4 |
| req_ptr | input | 4 | Pointer / direct register index |
| req_ofs | input | 4 | Offset register index for mode 5 |
| req_lit | input | 16 | Literal: absolute address or offset |
| req_wr | input | 1 | Write enable for register direct mode |
| req_wdata | input | 16 | Data written in register direct mode |
| ea_vld | output | 1 | Effective address valid strobe |
| ea_addr | output | 16 | Effective byte address |
| err_strb | output | 1 | Misaligned word access strobe |
| rd_vld | output | 1 | Register direct read strobe |
| rd_data | output | 16 | Register contents before the request |

## Verification
A wrong pointer update stays hidden at first. It shows only when the same register is next used. It can then appear as a wrong address on the following indirect request, or as a mismatched `rd_data` on a register direct read, at the earliest one cycle after the faulty write. The bench therefore reads back all sixteen registers at intervals, so a corrupted register cannot survive long. A wrong step size or a lost error suppression changes the alignment of later pointers. It then shows up as unexpected or missing error strobes. A wrong mode decode shows up at once, in the very next cycle's strobes or address.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    localparam int EAGU_AW   = 16;
    localparam int EAGU_NREG = 16;

    typedef enum logic [2:0] {
        AM_ABS   = 3'd0,
        AM_REG   = 3'd1,
        AM_IND   = 3'd2,
        AM_POST  = 3'd3,
        AM_PRE   = 3'd4,
        AM_ROFS  = 3'd5,
        AM_LOFS  = 3'd6,
        AM_RSVD  = 3'd7
    } amode_e;

    typedef struct packed {
        logic                ea_vld;
        logic                err;
        logic                rd_vld;
        logic [EAGU_AW-1:0]  ea;
        logic [EAGU_AW-1:0]  rd_data;
    } eagu_out_t;

    function automatic logic [EAGU_AW-1:0] step_of(input logic word, input logic dec);
        logic [EAGU_AW-1:0] mag;
        mag = word ? EAGU_AW'(2) : EAGU_AW'(1);
        return dec ? (~mag + EAGU_AW'(1)) : mag;
    endfunction

    function automatic logic is_mem_mode(input amode_e m);
        return (m != AM_REG) && (m != AM_RSVD);
    endfunction

    function automatic logic modifies_ptr(input amode_e m);
        return (m == AM_POST) || (m == AM_PRE);
    endfunction

endpackage

// File: rtl/eagu_regfile.sv
module eagu_regfile #(
    parameter int AW   = 16,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra_idx,
    output logic [AW-1:0] ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [AW-1:0] rb_data,
    input  logic          we,
    input  logic [IW-1:0] wa_idx,
    input  logic [AW-1:0] wa_data
);

    logic [AW-1:0] regs [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= '0;
                end else if (we && (wa_idx == IW'(g))) begin
                    regs[g] <= wa_data;
                end
            end
        end
    endgenerate

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

endmodule

// File: rtl/eagu_calc.sv
module eagu_calc
    import eagu_pkg::*;
#(
    parameter int AW = 16
) (
    input  amode_e        mode,
    input  logic          word,
    input  logic          dec,
    input  logic [AW-1:0] ptr_val,
    input  logic [AW-1:0] ofs_val,
    input  logic [AW-1:0] lit,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] new_ptr,
    output logic          mem_acc,
    output logic          misalign,
    output logic          ptr_upd
);

    logic [AW-1:0] stepped;

    always_comb begin
        stepped = ptr_val + step_of(word, dec);
        new_ptr = stepped;
        unique case (mode)
            AM_ABS:  ea = lit;
            AM_IND:  ea = ptr_val;
            AM_POST: ea = ptr_val;
            AM_PRE:  ea = stepped;
            AM_ROFS: ea = ptr_val + ofs_val;
            AM_LOFS: ea = ptr_val + lit;
            default: ea = '0;
        endcase
        mem_acc  = is_mem_mode(mode);
        misalign = mem_acc && word && ea[0];
        ptr_upd  = modifies_ptr(mode) && !misalign;
    end

endmodule

// File: rtl/eagu_top.sv
module eagu_top
    import eagu_pkg::*;
#(
    parameter int AW   = EAGU_AW,
    parameter int NREG = EAGU_NREG,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_vld,
    input  logic [2:0]    req_mode,
    input  logic          req_word,
    input  logic          req_dec,
    input  logic [IW-1:0] req_ptr,
    input  logic [IW-1:0] req_ofs,
    input  logic [AW-1:0] req_lit,
    input  logic          req_wr,
    input  logic [AW-1:0] req_wdata,
    output logic          ea_vld,
    output logic [AW-1:0] ea_addr,
    output logic          err_strb,
    output logic          rd_vld,
    output logic [AW-1:0] rd_data
);

    amode_e        mode;
    logic [AW-1:0] ptr_val;
    logic [AW-1:0] ofs_val;
    logic [AW-1:0] calc_ea;
    logic [AW-1:0] calc_np;
    logic          calc_mem;
    logic          calc_mis;
    logic          calc_upd;
    logic          wb_en;
    logic [AW-1:0] wb_data;
    logic          reg_mode;

    assign mode     = amode_e'(req_mode);
    assign reg_mode = (mode == AM_REG);

    eagu_regfile #(.AW(AW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (req_ptr),
        .ra_data (ptr_val),
        .rb_idx  (req_ofs),
        .rb_data (ofs_val),
        .we      (wb_en),
        .wa_idx  (req_ptr),
        .wa_data (wb_data)
    );

    eagu_calc #(.AW(AW)) u_calc (
        .mode     (mode),
        .word     (req_word),
        .dec      (req_dec),
        .ptr_val  (ptr_val),
        .ofs_val  (ofs_val),
        .lit      (req_lit),
        .ea       (calc_ea),
        .new_ptr  (calc_np),
        .mem_acc  (calc_mem),
        .misalign (calc_mis),
        .ptr_upd  (calc_upd)
    );

    assign wb_en   = req_vld && ((reg_mode && req_wr) || calc_upd);
    assign wb_data = reg_mode ? req_wdata : calc_np;

    eagu_out_t nxt, cur;

    always_comb begin
        nxt.ea_vld  = req_vld && calc_mem && !calc_mis;
        nxt.err     = req_vld && calc_mis;
        nxt.rd_vld  = req_vld && reg_mode;
        nxt.ea      = calc_ea;
        nxt.rd_data = ptr_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign ea_vld   = cur.ea_vld;
    assign err_strb = cur.err;
    assign rd_vld   = cur.rd_vld;
    assign ea_addr  = cur.ea;
    assign rd_data  = cur.rd_data;

endmodule

// File: rtl/eagu_chk.sv
module eagu_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_vld,
    input logic [2:0]    req_mode,
    input logic          req_word,
    input logic [AW-1:0] req_lit,
    input logic [AW-1:0] ptr_val,
    input logic          ea_vld,
    input logic [AW-1:0] ea_addr,
    input logic          err_strb,
    input logic          rd_vld
);

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ea_vld, err_strb, rd_vld}));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !ea_vld && !err_strb && !rd_vld);

    assert_byte_no_err_R9: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !req_word) |=> !err_strb);

    assert_abs_addr_R2: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode == 3'd0 && !req_word) |=> (ea_vld && ea_addr == $past(req_lit)));

    assert_ind_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode == 3'd2 && !req_word) |=> (ea_vld && ea_addr == $past(ptr_val)));

    assert_rsvd_silent_R11: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode == 3'd7) |=> (!ea_vld && !err_strb && !rd_vld));

    assert_err_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (err_strb && !$past(req_vld)) |-> 1'b0);

endmodule

bind eagu_top eagu_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_mode (req_mode),
    .req_word (req_word),
    .req_lit  (req_lit),
    .ptr_val  (ptr_val),
    .ea_vld   (ea_vld),
    .ea_addr  (ea_addr),
    .err_strb (err_strb),
    .rd_vld   (rd_vld)
);

// File: tb/eagu_top_tb.sv
module eagu_top_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [2:0]  req_mode = '0;
    logic        req_word = 1'b0;
    logic        req_dec = 1'b0;
    logic [3:0]  req_ptr = '0;
    logic [3:0]  req_ofs = '0;
    logic [15:0] req_lit = '0;
    logic        req_wr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        ea_vld;
    logic [15:0] ea_addr;
    logic        err_strb;
    logic        rd_vld;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    eagu_top u_dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_mode(req_mode),
        .req_word(req_word), .req_dec(req_dec), .req_ptr(req_ptr),
        .req_ofs(req_ofs), .req_lit(req_lit), .req_wr(req_wr),
        .req_wdata(req_wdata), .ea_vld(ea_vld), .ea_addr(ea_addr),
        .err_strb(err_strb), .rd_vld(rd_vld), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic issue(input logic [2:0] m, input bit w, input bit d, input logic [3:0] p,
                         input logic [3:0] o, input logic [15:0] lit, input bit wr, input logic [15:0] wd);
        logic [15:0] pv, ov, st, np, ea;
        bit mem, err, evld, rvld;
        pv = model[p];
        ov = model[o];
        st = w ? 16'd2 : 16'd1;
        np = d ? pv - st : pv + st;
        case (m)
            3'd0: ea = lit;
            3'd2: ea = pv;
            3'd3: ea = pv;
            3'd4: ea = np;
            3'd5: ea = pv + ov;
            3'd6: ea = pv + lit;
            default: ea = 16'h0;
        endcase
        mem  = (m != 3'd1) && (m != 3'd7);
        err  = mem && w && ea[0];
        evld = mem && !err;
        rvld = (m == 3'd1);
        req_vld = 1'b1; req_mode = m; req_word = w; req_dec = d; req_ptr = p;
        req_ofs = o; req_lit = lit; req_wr = wr; req_wdata = wd;
        @(negedge clk);
        chk(ea_vld == evld, {tag_of(m), " ea_vld"}, 16'(ea_vld), 16'(evld));
        chk(err_strb == err, "R9 err_strb", 16'(err_strb), 16'(err));
        chk(rd_vld == rvld, "R12 rd_vld", 16'(rd_vld), 16'(rvld));
        if (evld) chk(ea_addr == ea, {tag_of(m), " ea_addr"}, ea_addr, ea);
        if (rvld) chk(rd_data == pv, "R3 rd_data", rd_data, pv);
        if (m == 3'd1 && wr) model[p] = wd;
        if ((m == 3'd3 || m == 3'd4) && !err) model[p] = np;
    endtask

    task automatic idle();
        req_vld = 1'b0;
        @(negedge clk);
        chk(!ea_vld && !err_strb && !rd_vld, "R12 idle strobes", 16'({ea_vld, err_strb, rd_vld}), 16'h0);
    endtask

    task automatic readback_all();
        for (int i = 0; i < 16; i++) issue(3'd1, 1'b0, 1'b0, 4'(i), 4'd0, 16'h0, 1'b0, 16'h0);
    endtask

    task automatic wr_reg(input logic [3:0] p, input logic [15:0] v);
        issue(3'd1, 1'b0, 1'b0, p, 4'd0, 16'h0, 1'b1, v);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) model[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports and in every register
        chk(!ea_vld && !err_strb && !rd_vld, "R1 strobes after reset", 16'({ea_vld, err_strb, rd_vld}), 16'h0);
        readback_all();

        // directed corner cases
        wr_reg(4'd1, 16'hFFFE);
        issue(3'd3, 1'b1, 1'b0, 4'd1, 4'd0, 16'h0, 1'b0, 16'h0); // R5 word post-inc wraps to 0000
        wr_reg(4'd2, 16'h0000);
        issue(3'd4, 1'b0, 1'b1, 4'd2, 4'd0, 16'h0, 1'b0, 16'h0); // R6 byte pre-dec wraps to FFFF
        issue(3'd4, 1'b1, 1'b1, 4'd2, 4'd0, 16'h0, 1'b0, 16'h0); // R6 word to FFFD: odd -> R9/R10
        issue(3'd3, 1'b1, 1'b0, 4'd2, 4'd0, 16'h0, 1'b0, 16'h0); // R10 post-step on odd pointer blocked
        issue(3'd2, 1'b0, 1'b0, 4'd2, 4'd0, 16'h0, 1'b0, 16'h0); // R10 pointer still FFFF
        issue(3'd0, 1'b1, 1'b0, 4'd0, 4'd0, 16'h1235, 1'b0, 16'h0); // R9 odd absolute word
        issue(3'd0, 1'b0, 1'b0, 4'd0, 4'd0, 16'h1235, 1'b0, 16'h0); // R2 odd absolute byte
        wr_reg(4'd3, 16'h8001);
        issue(3'd5, 1'b1, 1'b0, 4'd3, 4'd2, 16'h0, 1'b0, 16'h0); // R7 8001+FFFF = 8000
        issue(3'd6, 1'b0, 1'b0, 4'd3, 4'd0, 16'h7FFF, 1'b0, 16'h0); // R8 wrap to 0000
        issue(3'd7, 1'b1, 1'b0, 4'd3, 4'd0, 16'h0, 1'b1, 16'hDEAD); // R11 reserved
        idle();
        readback_all();

        // constrained random traffic
        for (int n = 0; n < 1500; n++) begin
            logic [2:0] m;
            m = 3'($urandom_range(0, 7));
            if (($urandom_range(0, 9)) == 0) idle();
            issue(m, 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom),
                  16'($urandom), 1'($urandom), 16'($urandom));
            if ((n % 100) == 99) readback_all();
        end
        readback_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule